// File: doc/BRIEF.md
# SIMD Floating-Point Compare-to-Zero Unit

This unit decodes one instruction word and evaluates "element is greater than or equal to zero" on every active floating-point lane of a 128-bit operand. Each lane that passes the test returns all ones, and each lane that fails returns all zeros. The element width and the number of lanes are decoded from the instruction word on every operation. The scalar forms process one element. The vector forms cover 64 or 128 bits. Half, single and double precision are supported.

The unit sits in the execute stage after operand read. Each accepted operation produces a registered result one clock later. The result comes with the destination register index, an undefined-instruction flag for encodings that are not allocated, and an invalid-operation flag raised when any active lane holds a NaN. The unit only reports that flag. Delivering the exception and writing the register file are left to the surrounding pipeline.

A two-state machine controls the output side. `ST_IDLE` means no result is being presented. `ST_OUT` means `out_valid` is high for one captured operation. Every clock edge takes the transition `ST_IDLE/ST_OUT -> ST_OUT` when `in_valid` is high, and the transition `ST_IDLE/ST_OUT -> ST_IDLE` when it is low. Reset forces `ST_IDLE`.

Top module: `fpcmp_ge0_unit`

## Requirements
- R1: For each active lane, the lane's bits in `out_mask` are all ones when the element is a non-NaN with sign bit 0 (positive, +0, +infinity), and all zeros when the element is negative and non-zero. Lane 0 occupies the least significant bits.
- R2: A negative-zero element compares true and gives all ones. A NaN element (exponent all ones, fraction non-zero) in an active lane gives all zeros and sets `out_invalid`. A NaN in an inactive lane has no effect on `out_invalid`.
- R3: `out_rd` presents bits [4:0] of the captured instruction word.
- R4: An encoding is defined only if all of these hold: bit31=0, bit29=1, bits[27:23]=11101, bit21=1, bits[18:10]=000110010, and bit30=1 whenever bit28=1. Bit28=1 selects a scalar form and bit28=0 a vector form, with bit30 as the 128-bit select. Bits[20:19]=11 with bit22=1 selects half precision. Bits[20:19]=00 selects single precision (bit22=0) or double precision (bit22=1). Any other value flags `out_undef`.
- R5: The element width is 16, 32 or 64 bits. A scalar form uses one lane. A vector form spans 64 bits (bit30=0) or 128 bits (bit30=1), divided by the element width. Every `out_mask` bit above the active span is zero.
- R6: A vector double-precision encoding with bit30=0 sets `out_undef`.
- R7: A half-precision encoding sets `out_undef` when `half_en` is 0.
- R8: When `out_undef` is set, `out_mask` is all zeros and `out_invalid` is 0.
- R9: The outputs are registered when `in_valid` is high. `out_valid` is high in exactly the cycle after each cycle that has `in_valid` high. Without `in_valid`, the other outputs keep their values.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_mask`, `out_rd`, `out_undef` and `out_invalid` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| insn | input | 32 | Instruction word |
| operand | input | 128 | Source register value |
| half_en | input | 1 | Half-precision forms enabled |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_mask | output | 128 | Per-lane all-ones/all-zeros result |
| out_rd | output | 5 | Destination register index |
| out_undef | output | 1 | Encoding not allocated or disabled |
| out_invalid | output | 1 | NaN seen in an active lane |

## Verification
A decode error in lane width or lane count shows up one cycle after the strobe in two ways: mask bits appear above the active span, or a mask that is a single lane wide is split across neighbouring elements. Both are visible in the very next `out_valid` cycle. A lane that treats a signed zero, an infinity or a NaN wrongly flips that lane's mask and may also flip `out_invalid` in the same cycle. A fault in the output state machine shows as `out_valid` high without a preceding strobe, or as outputs drifting during idle cycles. The bench mixes directed special values with seeded random encodings and operands to expose these cases.

// File: rtl/fpcmp_ge0_pkg.sv
package fpcmp_ge0_pkg;

    localparam int INSN_W     = 32;
    localparam int LANE_CNT_W = 4;
    localparam int NUM_FMT    = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } fp_fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;

    typedef struct packed {
        fp_fmt_e                 fmt;
        logic [LANE_CNT_W-1:0]   lanes;
        logic                    undef;
    } dec_t;

endpackage

// File: rtl/fpcmp_ge0_decode.sv
module fpcmp_ge0_decode
    import fpcmp_ge0_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [INSN_W-1:10] op_bits,
    input  logic               half_en,
    output dec_t               dec
);

    localparam int HALF_SPAN = DATA_W / 2;

    logic fixed_ok;
    logic scalar;
    logic wide;
    logic is_half;
    logic is_sd;
    int   esize;

    always_comb begin
        fixed_ok = !op_bits[31] && op_bits[29] && (op_bits[27:23] == 5'b11101)
                   && op_bits[21] && (op_bits[18:10] == 9'b000110010);
        scalar   = op_bits[28];
        wide     = op_bits[30];
        is_half  = (op_bits[20:19] == 2'b11) && op_bits[22];
        is_sd    = (op_bits[20:19] == 2'b00);

        dec.undef = !fixed_ok || (scalar && !wide);
        dec.fmt   = FMT_SINGLE;
        esize     = 32;
        if (is_half) begin
            dec.fmt   = FMT_HALF;
            esize     = 16;
            dec.undef = dec.undef || !half_en;
        end else if (is_sd) begin
            dec.fmt = op_bits[22] ? FMT_DOUBLE : FMT_SINGLE;
            esize   = op_bits[22] ? 64 : 32;
            if (!scalar && !wide && op_bits[22]) begin
                dec.undef = 1'b1;
            end
        end else begin
            dec.undef = 1'b1;
        end

        if (scalar) begin
            dec.lanes = LANE_CNT_W'(1);
        end else if (wide) begin
            dec.lanes = LANE_CNT_W'(DATA_W / esize);
        end else begin
            dec.lanes = LANE_CNT_W'(HALF_SPAN / esize);
        end
    end

endmodule

// File: rtl/fpcmp_ge0_lanes.sv
module fpcmp_ge0_lanes
    import fpcmp_ge0_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ELEM_W = 16
) (
    input  logic [DATA_W-1:0]     operand,
    input  logic [LANE_CNT_W-1:0] act_lanes,
    output logic [DATA_W-1:0]     mask,
    output logic                  nan_seen
);

    localparam int NLANE  = DATA_W / ELEM_W;
    localparam int EXP_W  = (ELEM_W == 16) ? 5 : (ELEM_W == 32) ? 8 : 11;
    localparam int FRAC_W = ELEM_W - 1 - EXP_W;

    logic [NLANE-1:0] lane_nan;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [ELEM_W-1:0] elem;
        logic              sgn;
        logic              is_nan;
        logic              zero_mag;
        logic              active;
        logic              pass;

        assign elem     = operand[i*ELEM_W +: ELEM_W];
        assign sgn      = elem[ELEM_W-1];
        assign is_nan   = (&elem[ELEM_W-2 -: EXP_W]) && (|elem[FRAC_W-1:0]);
        assign zero_mag = ~|elem[ELEM_W-2:0];
        assign active   = LANE_CNT_W'(i) < act_lanes;
        assign pass     = !is_nan && (!sgn || zero_mag);
        assign mask[i*ELEM_W +: ELEM_W] = {ELEM_W{active && pass}};
        assign lane_nan[i] = active && is_nan;
    end

    assign nan_seen = |lane_nan;

endmodule

// File: rtl/fpcmp_ge0_unit.sv
module fpcmp_ge0_unit
    import fpcmp_ge0_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] operand,
    input  logic              half_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_mask,
    output logic [REG_W-1:0]  out_rd,
    output logic              out_undef,
    output logic              out_invalid
);

    dec_t               dec;
    logic [DATA_W-1:0]  fmt_mask [NUM_FMT];
    logic [NUM_FMT-1:0] fmt_nan;
    logic [DATA_W-1:0]  mask_d;
    logic               inv_d;
    out_state_e         state_q;
    out_state_e         state_d;
    logic               unused_rn;

    assign unused_rn = ^insn[9:REG_W];

    fpcmp_ge0_decode #(.DATA_W(DATA_W)) u_dec (
        .op_bits (insn[INSN_W-1:10]),
        .half_en (half_en),
        .dec     (dec)
    );

    for (genvar k = 0; k < NUM_FMT; k++) begin : g_fmt
        fpcmp_ge0_lanes #(.DATA_W(DATA_W), .ELEM_W(16 << k)) u_lanes (
            .operand   (operand),
            .act_lanes (dec.lanes),
            .mask      (fmt_mask[k]),
            .nan_seen  (fmt_nan[k])
        );
    end

    always_comb begin
        mask_d = '0;
        inv_d  = 1'b0;
        unique case (dec.fmt)
            FMT_HALF:   begin mask_d = fmt_mask[0]; inv_d = fmt_nan[0]; end
            FMT_SINGLE: begin mask_d = fmt_mask[1]; inv_d = fmt_nan[1]; end
            FMT_DOUBLE: begin mask_d = fmt_mask[2]; inv_d = fmt_nan[2]; end
            default:    begin mask_d = '0;          inv_d = 1'b0;       end
        endcase
        if (dec.undef) begin
            mask_d = '0;
            inv_d  = 1'b0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_mask    <= '0;
            out_rd      <= '0;
            out_undef   <= 1'b0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_mask    <= mask_d;
            out_rd      <= insn[REG_W-1:0];
            out_undef   <= dec.undef;
            out_invalid <= inv_d;
        end
    end

    assign out_valid = (state_q == ST_OUT);

endmodule

// File: rtl/fpcmp_ge0_chk.sv
module fpcmp_ge0_chk #(
    parameter int DATA_W = 128,
    parameter int REG_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       insn,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_mask,
    input logic [REG_W-1:0]  out_rd,
    input logic              out_undef,
    input logic              out_invalid
);

    localparam int NCHUNK = DATA_W / 16;

    logic unused_insn;
    assign unused_insn = ^{insn[31], insn[29], insn[27:REG_W]};

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_mask) && $stable(out_rd)
                      && $stable(out_undef) && $stable(out_invalid)));

    // R3
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_rd == $past(insn[REG_W-1:0])));

    // R8
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_undef) |-> ((out_mask == '0) && !out_invalid));

    // R5
    narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (insn[28] || !insn[30])) |=> (out_mask[DATA_W-1:DATA_W/2] == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_mask == '0) && (out_rd == '0)
                 && !out_undef && !out_invalid));

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        // R1
        lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> ((out_mask[c*16 +: 16] == 16'h0000)
                           || (out_mask[c*16 +: 16] == 16'hFFFF)));
    end

endmodule

bind fpcmp_ge0_unit fpcmp_ge0_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/fpcmp_ge0_unit_test.sv
`timescale 1ns/1ps
module fpcmp_ge0_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] operand = '0;
    logic         half_en = 1'b1;
    logic         out_valid;
    logic [127:0] out_mask;
    logic [4:0]   out_rd;
    logic         out_undef;
    logic         out_invalid;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #10 clk = ~clk;

    fpcmp_ge0_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .operand(operand), .half_en(half_en), .out_valid(out_valid),
        .out_mask(out_mask), .out_rd(out_rd), .out_undef(out_undef),
        .out_invalid(out_invalid)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // fmt: 0 half, 1 single, 2 double
    function automatic logic [31:0] mk(input bit scalar, input bit q, input int fmt,
                                       input logic [4:0] rn, input logic [4:0] rd);
        logic [31:0] w;
        w = '0;
        w[30]    = scalar ? 1'b1 : q;
        w[29]    = 1'b1;
        w[28]    = scalar;
        w[27:23] = 5'b11101;
        w[22]    = (fmt != 1);
        w[21]    = 1'b1;
        w[20:19] = (fmt == 0) ? 2'b11 : 2'b00;
        w[18:10] = 9'b000110010;
        w[9:5]   = rn;
        w[4:0]   = rd;
        return w;
    endfunction

    function automatic logic [129:0] model(input logic [31:0] w, input logic [127:0] op,
                                           input logic hen);
        logic bad, inv, nan, ge;
        logic [127:0] m;
        logic [63:0]  el;
        int ew, cnt;
        bad = 0; inv = 0; m = '0; ew = 32; nan = 0; ge = 0;
        if (w[31] || !w[29] || w[27:23] != 5'b11101 || !w[21] || w[18:10] != 9'b000110010)
            bad = 1;
        if (w[28] && !w[30]) bad = 1;
        if (w[20:19] == 2'b11 && w[22]) begin
            ew = 16;
            if (!hen) bad = 1;
        end else if (w[20:19] == 2'b00) begin
            ew = w[22] ? 64 : 32;
            if (!w[28] && !w[30] && w[22]) bad = 1;
        end else begin
            bad = 1;
        end
        cnt = w[28] ? 1 : ((w[30] ? 128 : 64) / ew);
        if (!bad) begin
            for (int e = 0; e < cnt; e++) begin
                el = 64'(op >> (e * ew));
                case (ew)
                    16: begin nan = &el[14:10] && |el[9:0];
                              ge = !nan && (!el[15] || el[14:0] == 0); end
                    32: begin nan = &el[30:23] && |el[22:0];
                              ge = !nan && (!el[31] || el[30:0] == 0); end
                    default: begin nan = &el[62:52] && |el[51:0];
                              ge = !nan && (!el[63] || el[62:0] == 0); end
                endcase
                if (nan) inv = 1;
                for (int b = 0; b < ew; b++) m[e*ew + b] = ge;
            end
        end
        return {bad, inv, m};
    endfunction

    function automatic logic [63:0] spec(input int ew, input int kind);
        logic [63:0] v;
        case (ew)
            16: case (kind)
                    0: v = 64'h0000; 1: v = 64'h8000; 2: v = 64'h7E00;
                    3: v = 64'h7C00; 4: v = 64'hFC00; default: v = 64'h7C01;
                endcase
            32: case (kind)
                    0: v = 64'h0; 1: v = 64'h80000000; 2: v = 64'h7FC00000;
                    3: v = 64'h7F800000; 4: v = 64'hFF800000; default: v = 64'h7F800001;
                endcase
            default: case (kind)
                    0: v = 64'h0; 1: v = 64'h8000000000000000; 2: v = 64'h7FF8000000000000;
                    3: v = 64'h7FF0000000000000; 4: v = 64'hFFF0000000000000;
                    default: v = 64'h7FF0000000000001;
                endcase
        endcase
        return v;
    endfunction

    task automatic issue(input logic [31:0] w, input logic [127:0] op, input logic hen);
        @(negedge clk);
        insn = w; operand = op; half_en = hen; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic verify(input string tag, input logic [31:0] w,
                          input logic [127:0] op, input logic hen);
        logic [129:0] r;
        r = model(w, op, hen);
        chk(tag, "mask", out_mask, r[127:0]);
        chk(tag, "undef", 128'(out_undef), 128'(r[129]));
        chk(tag, "invalid", 128'(out_invalid), 128'(r[128]));
        chk("R3", "rd", 128'(out_rd), 128'(w[4:0]));
        chk("R9", "valid", 128'(out_valid), 128'd1);
    endtask

    initial begin
        logic [31:0]  w;
        logic [127:0] op;
        logic [127:0] prev;
        logic         hen;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10", "valid", 128'(out_valid), 128'd0);
        chk("R10", "mask", out_mask, 128'd0);
        chk("R10", "undef/invalid/rd", 128'({out_undef, out_invalid, out_rd}), 128'd0);

        // R1 R2 vector single 128: +1, -1, -0, +0
        w = mk(0, 1, 1, 5'd3, 5'd7);
        op = {32'h00000000, 32'h80000000, 32'hBF800000, 32'h3F800000};
        issue(w, op, 1);
        chk("R1", "single lanes", out_mask,
            {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF});
        chk("R2", "no nan invalid", 128'(out_invalid), 128'd0);
        chk("R3", "rd", 128'(out_rd), 128'd7);

        // R9 idle cycle keeps outputs
        prev = out_mask;
        @(negedge clk);
        chk("R9", "idle valid", 128'(out_valid), 128'd0);
        chk("R9", "idle hold", out_mask, prev);

        // R2 NaN in active half lane
        w = mk(0, 1, 0, 5'd1, 5'd30);
        op = {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'h7E00, 16'h3C00, 16'h3C00, 16'h3C00};
        issue(w, op, 1);
        chk("R2", "nan lane", out_mask,
            {64'hFFFFFFFFFFFFFFFF, 16'h0000, 48'hFFFFFFFFFFFF});
        chk("R2", "nan invalid", 128'(out_invalid), 128'd1);

        // R5 R2 NaN in inactive lane, vector half 64
        w = mk(0, 0, 0, 5'd2, 5'd4);
        op = {16'h3C00, 16'h3C00, 16'h7E00, 16'h3C00, 16'hBC00, 16'hBC00, 16'hBC00, 16'h0000};
        issue(w, op, 1);
        chk("R5", "half64 mask", out_mask, 128'h0000FFFF);
        chk("R2", "inactive nan", 128'(out_invalid), 128'd0);

        // R5 scalar double +inf with upper garbage
        w = mk(1, 0, 2, 5'd9, 5'd11);
        op = {64'hFFFFFFFFFFFFFFFF, 64'h7FF0000000000000};
        issue(w, op, 1);
        chk("R5", "scalar double", out_mask, {64'h0, 64'hFFFFFFFFFFFFFFFF});

        // R2 scalar single negative NaN
        w = mk(1, 0, 1, 5'd0, 5'd1);
        op = {96'h0, 32'hFFC00000};
        issue(w, op, 1);
        chk("R2", "neg nan mask", out_mask, 128'd0);
        chk("R2", "neg nan invalid", 128'(out_invalid), 128'd1);

        // R6 R8 vector double 64 is undefined
        w = mk(0, 0, 2, 5'd0, 5'd5);
        op = {64'h7FF8000000000000, 64'h0};
        issue(w, op, 1);
        chk("R6", "undef", 128'(out_undef), 128'd1);
        chk("R8", "undef mask", out_mask, 128'd0);
        chk("R8", "undef invalid", 128'(out_invalid), 128'd0);

        // R7 half disabled
        w = mk(0, 1, 0, 5'd0, 5'd6);
        issue(w, 128'h0, 0);
        chk("R7", "half off undef", 128'(out_undef), 128'd1);
        issue(w, 128'h0, 1);
        chk("R7", "half on defined", 128'(out_undef), 128'd0);

        // R4 corrupted fixed bit and class bits
        w = mk(0, 1, 1, 5'd0, 5'd8);
        w[10] = 1'b1;
        issue(w, 128'h0, 1);
        chk("R4", "fixed bit", 128'(out_undef), 128'd1);
        w = mk(0, 1, 1, 5'd0, 5'd8);
        w[20:19] = 2'b01;
        issue(w, 128'h0, 1);
        chk("R4", "class bits", 128'(out_undef), 128'd1);
        w = mk(1, 0, 1, 5'd0, 5'd8);
        w[30] = 1'b0;
        issue(w, 128'h0, 1);
        chk("R4", "scalar bit30", 128'(out_undef), 128'd1);

        // Random mix
        for (int t = 0; t < 400; t++) begin
            int fmt, ew;
            bit sc, q;
            sc  = ($urandom % 4) == 0;
            q   = $urandom % 2;
            fmt = $urandom % 3;
            hen = ($urandom % 8) != 0;
            w   = mk(sc, q, fmt, 5'($urandom), 5'($urandom));
            if (($urandom % 10) == 0) w[10 + ($urandom % 22)] ^= 1'b1;
            op  = {$urandom, $urandom, $urandom, $urandom};
            ew  = 16 << fmt;
            for (int e = 0; e < 128 / ew; e++) begin
                if (($urandom % 3) == 0) begin
                    logic [63:0] sp;
                    sp = spec(ew, $urandom % 6);
                    case (ew)
                        16: op[e*16 +: 16] = sp[15:0];
                        32: op[e*32 +: 32] = sp[31:0];
                        default: op[e*64 +: 64] = sp;
                    endcase
                end
            end
            issue(w, op, hen);
            verify("R1", w, op, hen);
        end

        // R10 reset mid-run
        issue(mk(0, 1, 1, 5'd0, 5'd31), 128'h0, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "mid valid", 128'(out_valid), 128'd0);
        chk("R10", "mid mask/rd", {out_mask[122:0], out_rd}, 128'd0);

        finish_run();
    end

endmodule